// File: doc/BRIEF.md
# Programmable 16-bit Timer Channel

This block is one up-counting timer channel with a 16-bit counter, a 16-bit compare value and a five-bit control word. Each count step comes from one of two sources. The first is a tick from a shared prescaler. The second is a rising edge on an asynchronous external pin, which lets the channel act as an event counter. When the counter equals the compare value on a tick, it returns to zero and raises a one-cycle match pulse. Each match also flips an internal toggle, and that toggle can drive a timer clock output pin.

Software reaches the channel through a small register port, which has an address, a write strobe, write data and registered read data. The control word has these bits:

| Bit | Name | Effect |
|-----|------|--------|
| 0 | run | enables counting |
| 1 | clear | write-one counter clear |
| 2 | gate | enables the output |
| 3 | source | selects the count source |
| 4 | invert | selects the output polarity and the idle level |

When the gate bit is 0, the output pin rests at the level of the invert bit.

Top module: `tmr_channel`

## Requirements
- R1: After reset, the control word reads 0, the count reads 0, the compare register reads 0xFFFF, the output pin is low and the match pulse is low.
- R2: Register map: address 0 is the control word, address 1 is the compare value, and address 2 is the count, which is read-only. Read data appears on the clock edge after the address is presented. In the control word, bits 0, 2, 3 and 4 read back their written values. Bit 1 always reads 0.
- R3: With source bit 3 at 0 and run bit 0 at 1, the counter advances by exactly one on each clock where the prescaler tick is high, and on no other clock.
- R4: With run bit 0 at 0, the counter holds its value while ticks arrive.
- R5: On a tick with the count equal to the compare value, the counter returns to 0 and match_o is high for the following cycle. One match period is therefore compare+1 ticks.
- R6: Writing 1 to control bit 1 sets the counter to 0 on that clock, even when a tick arrives in the same clock. A control write with bit 1 at 0 leaves the count unchanged.
- R7: With source bit 3 at 1, each rising edge of ext_clk_i counts as one tick, after a two-flop synchronizer and an edge detector. The prescaler tick is then ignored.
- R8: With gate bit 2 at 1, the output pin equals the match toggle XOR invert bit 4. It changes once per match, one cycle after the match.
- R9: With gate bit 2 at 0, the output pin holds the level of invert bit 4 while the counter runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Registered read data |
| presc_tick_i | input | 1 | Internal prescaler tick |
| ext_clk_i | input | 1 | Asynchronous external event input |
| tmr_out_o | output | 1 | Timer clock output pin |
| match_o | output | 1 | One-cycle compare match pulse |

## Verification
On every cycle, the assertions check several local relationships:
- a count with no tick and no clear holds its value;
- a clear forces zero;
- a tick at the compare value wraps the count and pulses match;
- every match flips the toggle;
- control writes land in the register;
- a gated-off pin sits at the invert level;
- a detected external edge lasts one cycle.

Other behaviour only shows at the ports over a stretch of cycles, so only the bench scenarios can confirm it. That covers the arithmetic of the wrap period across compare values, the count of matches over long runs, the output phase after many matches, and the count of external events after synchronization. It also covers the clear-over-tick priority and the bit that always reads 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W    = 2;
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_CLR  = 1;
  localparam int CTRL_GATE = 2;
  localparam int CTRL_SRC  = 3;
  localparam int CTRL_INV  = 4;

  localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] REG_CMP  = 2'd1;
  localparam logic [ADDR_W-1:0] REG_CNT  = 2'd2;

  typedef struct packed {
    logic inv;
    logic src;
    logic gate;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R7
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int               CNT_W    = 16,
  parameter logic [CNT_W-1:0] CMP_INIT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output ctrl_t             ctrl_o,
  output logic              clr_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [CNT_W-1:0]  rdata_o
);
  logic ctrl_wr;
  logic cmp_wr;

  assign ctrl_wr = wr_en_i && (addr_i == REG_CTRL);
  assign cmp_wr  = wr_en_i && (addr_i == REG_CMP);
  assign clr_o   = ctrl_wr && wdata_i[CTRL_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
      cmp_o  <= CMP_INIT;
    end else begin
      if (ctrl_wr) begin
        ctrl_o.run  <= wdata_i[CTRL_RUN];
        ctrl_o.gate <= wdata_i[CTRL_GATE];
        ctrl_o.src  <= wdata_i[CTRL_SRC];
        ctrl_o.inv  <= wdata_i[CTRL_INV];
      end
      if (cmp_wr) cmp_o <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= '0;
      case (addr_i)
        REG_CTRL: begin
          rdata_o[CTRL_RUN]  <= ctrl_o.run;
          rdata_o[CTRL_GATE] <= ctrl_o.gate;
          rdata_o[CTRL_SRC]  <= ctrl_o.src;
          rdata_o[CTRL_INV]  <= ctrl_o.inv;
        end
        REG_CMP: rdata_o <= cmp_o;
        REG_CNT: rdata_o <= cnt_i;
        default: rdata_o <= '0;
      endcase
    end
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (ctrl_o.run == $past(wdata_i[CTRL_RUN])) &&
                (ctrl_o.src == $past(wdata_i[CTRL_SRC]))); // R2
  AST_CMP_WRITE: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> cmp_o == $past(wdata_i)); // R2
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o,
  output logic             tog_o
);
  logic at_cmp;
  assign at_cmp = (cnt_o == cmp_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o   <= '0;
      match_o <= 1'b0;
      tog_o   <= 1'b0;
    end else begin
      match_o <= 1'b0;
      if (clr_i) begin
        cnt_o <= '0;
      end else if (tick_i) begin
        if (at_cmp) begin
          cnt_o   <= '0;
          match_o <= 1'b1;
          tog_o   <= ~tog_o;
        end else begin
          cnt_o <= cnt_o + 1'b1;
        end
      end
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i) |=> $stable(cnt_o)); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_o == '0) && !match_o); // R6
  AST_WRAP_MATCH: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !clr_i && at_cmp) |=> match_o && (cnt_o == '0)); // R5
  AST_MATCH_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    match_o |-> tog_o != $past(tog_o)); // R8
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int               CNT_W       = 16,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] CMP_INIT    = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              presc_tick_i,
  input  logic              ext_clk_i,
  output logic              tmr_out_o,
  output logic              match_o
);
  ctrl_t            ctrl;
  logic             clr;
  logic [CNT_W-1:0] cmp;
  logic [CNT_W-1:0] cnt;
  logic             ext_rise;
  logic             tick;
  logic             tog;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (ext_clk_i),
    .rise_o  (ext_rise)
  );

  tmr_regs #(.CNT_W(CNT_W), .CMP_INIT(CMP_INIT)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cnt_i   (cnt),
    .ctrl_o  (ctrl),
    .clr_o   (clr),
    .cmp_o   (cmp),
    .rdata_o (rdata_o)
  );

  assign tick = ctrl.run & (ctrl.src ? ext_rise : presc_tick_i);

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .clr_i   (clr),
    .cmp_i   (cmp),
    .cnt_o   (cnt),
    .match_o (match_o),
    .tog_o   (tog)
  );

  always_ff @(posedge clk) begin
    if (rst) tmr_out_o <= 1'b0;
    else     tmr_out_o <= ctrl.gate ? (tog ^ ctrl.inv) : ctrl.inv;
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $past(!ctrl.gate) |-> tmr_out_o == $past(ctrl.inv)); // R9
  AST_EXT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ctrl.src && !ext_rise && !clr) |=> $stable(cnt)); // R7
  AST_GATED_OUT: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl.gate) |-> tmr_out_o == ($past(tog) ^ $past(ctrl.inv))); // R8
endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        tick = 1'b0;
  logic        ext = 1'b0;
  logic        tout;
  logic        match;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  tmr_channel u_dut (
    .clk (clk), .rst (rst), .wr_en_i (wr_en), .addr_i (addr), .wdata_i (wdata),
    .rdata_o (rdata), .presc_tick_i (tick), .ext_clk_i (ext),
    .tmr_out_o (tout), .match_o (match)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic        ob;
    logic        prev;
    logic        ok;
    int          m;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 out", tout, 0);
    chk("R1 match", match, 0);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(2, v); chk("R1 count", v, 0);
    rd(1, v); chk("R1 cmp", v, 16'hFFFF);

    // R2 readback, clear bit reads 0
    wr(0, 16'h001F); rd(0, v); chk("R2 ctrl readback", v, 16'h001D);
    wr(0, 16'h0000); rd(0, v); chk("R2 ctrl zero", v, 0);
    wr(1, 16'h1234); rd(1, v); chk("R2 cmp readback", v, 16'h1234);

    // R5 / R8 sweep over compare values and polarity
    for (int c = 0; c < 8; c++) begin
      for (int inv = 0; inv < 2; inv++) begin
        int n;
        n = 20 + c;
        wr(1, 16'(c));
        wr(0, 16'h0004 | 16'(inv << 4));
        tick = 1'b1;
        repeat (2) @(negedge clk);
        ob = tout;
        wr(0, 16'h0007 | 16'(inv << 4));
        m = 0;
        for (int i = 0; i < n; i++) begin
          @(negedge clk);
          if (match) m++;
        end
        tick = 1'b0;
        repeat (2) @(negedge clk);
        rd(2, v); chk("R5 count after run", v, 16'(n % (c + 1)));
        chk("R5 match pulses", m, n / (c + 1));
        chk("R8 output phase", tout, ob ^ m[0]);
      end
    end

    // R3 internal ticks in a sparse pattern
    wr(1, 16'hFFFF);
    wr(0, 16'h0003);
    for (int i = 0; i < 30; i++) begin
      tick = (i % 3 == 0);
      @(negedge clk);
    end
    tick = 1'b0;
    rd(2, v); chk("R3 sparse ticks", v, 10);

    // R4 run off holds
    wr(0, 16'h0000);
    tick = 1'b1;
    repeat (10) @(negedge clk);
    tick = 1'b0;
    rd(2, v); chk("R4 hold while stopped", v, 10);

    // R6 clear beats a simultaneous tick
    wr(0, 16'h0001);
    tick = 1'b1;
    repeat (5) @(negedge clk);
    wr(0, 16'h0003);
    tick = 1'b0;
    rd(2, v); chk("R6 clear with tick", v, 0);
    tick = 1'b1;
    repeat (4) @(negedge clk);
    tick = 1'b0;
    wr(0, 16'h0001);
    rd(2, v); chk("R6 write zero no effect", v, 4);

    // R7 external events, prescaler ignored
    wr(0, 16'h000B);
    tick = 1'b1;
    for (int k = 0; k < 7; k++) begin
      ext = 1'b1; repeat (3) @(negedge clk);
      ext = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(2, v); chk("R7 event count", v, 7);
    wr(1, 16'd2);
    wr(0, 16'h000B);
    m = 0;
    for (int k = 0; k < 7; k++) begin
      ext = 1'b1;
      repeat (3) begin @(negedge clk); if (match) m++; end
      ext = 1'b0;
      repeat (3) begin @(negedge clk); if (match) m++; end
    end
    repeat (4) begin @(negedge clk); if (match) m++; end
    tick = 1'b0;
    rd(2, v); chk("R7 event wrap count", v, 1);
    chk("R7 event matches", m, 2);

    // R9 gated-off idle level while running with cmp 0
    wr(1, 16'd0);
    tick = 1'b1;
    wr(0, 16'h0013);
    repeat (2) @(negedge clk);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (tout !== 1'b1) ok = 1'b0;
      @(negedge clk);
    end
    chk("R9 idle high", ok, 1);
    wr(0, 16'h0003);
    repeat (2) @(negedge clk);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (tout !== 1'b0) ok = 1'b0;
      @(negedge clk);
    end
    chk("R9 idle low", ok, 1);

    // R8 gate on, cmp 0: output flips every cycle
    wr(0, 16'h0005);
    repeat (2) @(negedge clk);
    prev = tout;
    ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (tout === prev) ok = 1'b0;
      prev = tout;
    end
    chk("R8 toggle each match", ok, 1);
    tick = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule